// File: doc/BRIEF.md
# Floating-Point Exception Trap Controller

This block sits beside a floating-point execution unit. It decides whether a finished operation, or an operand about to enter one, must raise an arithmetic trap. For a finished operation it takes the six exception flags the datapath produced, together with a per-instruction ignore mask, the enable mask from the control register, the destination register number, a software-completion qualifier and a user/system mode bit. From these it forms a trap request, a 7-bit exception summary and a one-hot register mask. It also keeps a sticky copy of every flag it has seen. Software can overwrite the sticky copy only through a dedicated write port.

The same block screens 64-bit operands before arithmetic or comparison instructions use them. Denormals, infinities and NaNs trap under rules that depend on the instruction class, on software completion and on an inputs-flush-to-zero control. All results are registered. A trap appears as a one-cycle pulse on the clock edge that captures the operation strobe. The summary and register mask are valid only during that pulse.

Top module: `fpx_trap_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, trap_pulse is 0, trap_summary and trap_regmask are zero, and sticky is zero.
- R2: A flag operation (op_kind 0) ORs all six flags into sticky, including the ignored ones. Sticky bits never clear except through sticky_wr. When sticky_wr and a flag operation coincide, sticky becomes sticky_wdata ORed with the new flags.
- R3: For a flag operation without software completion, a trap occurs when flags AND NOT ignore_mask is nonzero. The summary equals that value, enable_mask has no effect, and summary bit 6 is 0.
- R4: For a flag operation with software completion in user mode (user_mode=1), a trap occurs only when flags AND NOT ignore_mask AND enable_mask is nonzero.
- R5: For a flag operation with software completion in system mode (user_mode=0), a trap occurs when flags AND NOT ignore_mask is nonzero. The summary carries only the kept flags that are also enabled, so it can hold bit 6 alone.
- R6: Flag and summary bit positions are: invalid 0, divide-by-zero 1, overflow 2, underflow 3, inexact 4, integer overflow 5. Summary bit 6 is the software-completion marker, and it is set on every trap raised with swc=1.
- R7: A trap from a flag operation drives trap_regmask with the single bit at dest_reg. A screening trap drives a zero register mask. Without a trap, the summary and mask are zero.
- R8: Results appear on the rising edge that samples op_valid=1, and trap_pulse lasts one cycle. Without op_valid nothing traps and sticky changes only through sticky_wr.
- R9: A screen (op_kind 1 or 2) without software completion traps with summary 0x01 on a zero exponent with a nonzero fraction, and leaves sticky unchanged.
- R10: An arithmetic screen (op_kind 1) without software completion traps with summary 0x01 on an all-ones exponent, and sets sticky bit 0.
- R11: A comparison screen (op_kind 2) without software completion treats only a NaN (all-ones exponent, nonzero fraction) like R10. An infinity neither traps nor touches sticky.
- R12: A screen with software completion traps with summary 0x41 only for a zero exponent with a nonzero fraction, of either sign, and only when flush_inputs=0. Zeros, normals, infinities and NaNs pass, and sticky is unchanged.
- R13: op_kind 3 is reserved: it raises no trap and leaves sticky unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Strobe: evaluate the request this cycle |
| op_kind | input | 2 | 0 flag check, 1 arithmetic screen, 2 comparison screen, 3 reserved |
| flags | input | 6 | Operation exception flags (R6 positions) |
| ignore_mask | input | 6 | Per-instruction flags that never trap |
| enable_mask | input | 6 | Trap enables from the control register |
| dest_reg | input | 5 | Destination register number |
| swc | input | 1 | Software-completion qualifier |
| user_mode | input | 1 | 1 user policy, 0 system policy |
| flush_inputs | input | 1 | Inputs-flush-to-zero control |
| operand | input | 64 | Source operand to screen |
| sticky_wr | input | 1 | Load sticky from sticky_wdata |
| sticky_wdata | input | 6 | Value loaded into sticky |
| trap_pulse | output | 1 | One-cycle trap request |
| trap_summary | output | 7 | Exception summary word |
| trap_regmask | output | 32 | One-hot destination register mask |
| sticky | output | 6 | Sticky exception status |

## Verification
Every result is due exactly one rising edge after the inputs that caused it: the pulse, the summary, the mask and the sticky update all come from the same register stage. The bench applies each request at a falling edge and compares all four outputs at the next falling edge, half a period after the capturing edge. It then drives the following request at that same falling edge. Idle steps between requests confirm that the pulse falls after one cycle.

// File: rtl/fpx_trap_pkg.sv
package fpx_trap_pkg;

   localparam int FLAG_W  = 6;
   localparam int SUM_W   = FLAG_W + 1;

   localparam int BIT_INV = 0;
   localparam int BIT_DZE = 1;
   localparam int BIT_OVF = 2;
   localparam int BIT_UNF = 3;
   localparam int BIT_INE = 4;
   localparam int BIT_IOV = 5;
   localparam int BIT_SWC = FLAG_W;

   typedef enum logic [1:0] {
      OPK_FLAGS      = 2'd0,
      OPK_SCREEN_ARI = 2'd1,
      OPK_SCREEN_CMP = 2'd2,
      OPK_NONE       = 2'd3
   } op_kind_e;

   typedef logic [FLAG_W-1:0] flag_vec_t;
   typedef logic [SUM_W-1:0]  summary_t;

endpackage

// File: rtl/fpx_flag_policy.sv
module fpx_flag_policy
   import fpx_trap_pkg::*;
(
   input  flag_vec_t flags,
   input  flag_vec_t ignore_mask,
   input  flag_vec_t enable_mask,
   input  logic      swc,
   input  logic      user_mode,
   output logic      trap,
   output summary_t  summary
);

   flag_vec_t kept;
   flag_vec_t kept_enabled;

   always_comb begin
      kept         = flags & ~ignore_mask;
      kept_enabled = kept & enable_mask;
      summary      = '0;
      if (!swc) begin
         // plain rule: enable mask is not consulted
         trap                 = |kept;
         summary[FLAG_W-1:0]  = kept;
      end else begin
         // software completion: policy depends on privilege mode
         trap                 = user_mode ? |kept_enabled : |kept;
         summary[FLAG_W-1:0]  = kept_enabled;
         summary[BIT_SWC]     = 1'b1;
      end
   end

endmodule

// File: rtl/fpx_operand_screen.sv
module fpx_operand_screen
   import fpx_trap_pkg::*;
#(
   parameter int EXP_W       = 11,
   parameter int FRAC_W      = 52,
   parameter bit SWC_LITERAL = 1'b1,
   localparam int OPD_W      = 1 + EXP_W + FRAC_W
)(
   input  logic [OPD_W-1:0] operand,
   input  logic             is_compare,
   input  logic             swc,
   input  logic             flush_inputs,
   output logic             trap,
   output logic             set_invalid,
   output summary_t         summary
);

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_zero;
   logic              exp_ones;
   logic              frac_nz;
   logic              subnormal;
   logic              swc_tiny;

   assign exp_f     = operand[OPD_W-2 -: EXP_W];
   assign frac_f    = operand[FRAC_W-1:0];
   assign exp_zero  = (exp_f == '0);
   assign exp_ones  = (exp_f == '1);
   assign frac_nz   = (frac_f != '0);
   assign subnormal = exp_zero && frac_nz;

   generate
      if (SWC_LITERAL) begin : g_swc_arith
         // doubled operand minus one, compared unsigned against 2^(F+1)-1
         logic [OPD_W-1:0] twice_m1;
         logic [OPD_W-1:0] limit;
         assign twice_m1 = {operand[OPD_W-2:0], 1'b0} - {{(OPD_W-1){1'b0}}, 1'b1};
         assign limit    = {{(OPD_W-FRAC_W-1){1'b0}}, {(FRAC_W+1){1'b1}}};
         assign swc_tiny = (twice_m1 < limit);
      end else begin : g_swc_field
         assign swc_tiny = subnormal;
      end
   endgenerate

   always_comb begin
      trap        = 1'b0;
      set_invalid = 1'b0;
      summary     = '0;
      if (swc) begin
         if (swc_tiny && !flush_inputs) begin
            trap              = 1'b1;
            summary[BIT_INV]  = 1'b1;
            summary[BIT_SWC]  = 1'b1;
         end
      end else if (subnormal) begin
         trap             = 1'b1;
         summary[BIT_INV] = 1'b1;
      end else if (exp_ones && (frac_nz || !is_compare)) begin
         trap             = 1'b1;
         set_invalid      = 1'b1;
         summary[BIT_INV] = 1'b1;
      end
   end

endmodule

// File: rtl/fpx_reg_onehot.sv
module fpx_reg_onehot #(
   parameter int NUM_REGS = 32,
   localparam int REG_W   = $clog2(NUM_REGS)
)(
   input  logic [REG_W-1:0]    dest,
   output logic [NUM_REGS-1:0] onehot
);

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
         assign onehot[i] = (dest == REG_W'(i));
      end
   endgenerate

endmodule

// File: rtl/fpx_trap_ctrl.sv
module fpx_trap_ctrl
   import fpx_trap_pkg::*;
#(
   parameter int EXP_W       = 11,
   parameter int FRAC_W      = 52,
   parameter int NUM_REGS    = 32,
   parameter bit SWC_LITERAL = 1'b1,
   localparam int OPD_W      = 1 + EXP_W + FRAC_W,
   localparam int REG_W      = $clog2(NUM_REGS)
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                op_valid,
   input  logic [1:0]          op_kind,
   input  logic [FLAG_W-1:0]   flags,
   input  logic [FLAG_W-1:0]   ignore_mask,
   input  logic [FLAG_W-1:0]   enable_mask,
   input  logic [REG_W-1:0]    dest_reg,
   input  logic                swc,
   input  logic                user_mode,
   input  logic                flush_inputs,
   input  logic [OPD_W-1:0]    operand,
   input  logic                sticky_wr,
   input  logic [FLAG_W-1:0]   sticky_wdata,
   output logic                trap_pulse,
   output logic [SUM_W-1:0]    trap_summary,
   output logic [NUM_REGS-1:0] trap_regmask,
   output logic [FLAG_W-1:0]   sticky
);

   generate
      if (NUM_REGS < 2 || NUM_REGS > 64) begin : g_bad_regs
         $error("fpx_trap_ctrl: NUM_REGS must lie in 2..64");
      end
      if (EXP_W < 2 || FRAC_W < 1) begin : g_bad_fmt
         $error("fpx_trap_ctrl: exponent and fraction fields too narrow");
      end
   endgenerate

   op_kind_e  kind;
   logic      pol_trap;
   summary_t  pol_summary;
   logic      scr_trap;
   logic      scr_set_inv;
   summary_t  scr_summary;
   logic [NUM_REGS-1:0] dest_onehot;

   logic                trap_d;
   summary_t            summary_d;
   logic [NUM_REGS-1:0] regmask_d;
   flag_vec_t           set_d;

   assign kind = op_kind_e'(op_kind);

   fpx_flag_policy u_policy (
      .flags       (flags),
      .ignore_mask (ignore_mask),
      .enable_mask (enable_mask),
      .swc         (swc),
      .user_mode   (user_mode),
      .trap        (pol_trap),
      .summary     (pol_summary)
   );

   fpx_operand_screen #(
      .EXP_W       (EXP_W),
      .FRAC_W      (FRAC_W),
      .SWC_LITERAL (SWC_LITERAL)
   ) u_screen (
      .operand      (operand),
      .is_compare   (kind == OPK_SCREEN_CMP),
      .swc          (swc),
      .flush_inputs (flush_inputs),
      .trap         (scr_trap),
      .set_invalid  (scr_set_inv),
      .summary      (scr_summary)
   );

   fpx_reg_onehot #(.NUM_REGS(NUM_REGS)) u_onehot (
      .dest   (dest_reg),
      .onehot (dest_onehot)
   );

   always_comb begin
      trap_d    = 1'b0;
      summary_d = '0;
      regmask_d = '0;
      set_d     = '0;
      if (op_valid) begin
         unique case (kind)
            OPK_FLAGS: begin
               set_d     = flags;
               trap_d    = pol_trap;
               summary_d = pol_trap ? pol_summary : '0;
               regmask_d = pol_trap ? dest_onehot : '0;
            end
            OPK_SCREEN_ARI, OPK_SCREEN_CMP: begin
               trap_d           = scr_trap;
               summary_d        = scr_summary;
               set_d[BIT_INV]   = scr_set_inv;
            end
            default: begin
               trap_d = 1'b0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trap_pulse   <= 1'b0;
         trap_summary <= '0;
         trap_regmask <= '0;
      end else begin
         trap_pulse   <= trap_d;
         trap_summary <= summary_d;
         trap_regmask <= regmask_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky <= '0;
      end else if (sticky_wr || (set_d != '0)) begin
         sticky <= (sticky_wr ? sticky_wdata : sticky) | set_d;
      end
   end

endmodule

// File: rtl/fpx_trap_ctrl_chk.sv
module fpx_trap_ctrl_chk #(
   parameter int NUM_REGS = 32
)(
   input logic                clk,
   input logic                rst_n,
   input logic                op_valid,
   input logic [1:0]          op_kind,
   input logic                swc,
   input logic                sticky_wr,
   input logic                trap_pulse,
   input logic [6:0]          trap_summary,
   input logic [NUM_REGS-1:0] trap_regmask,
   input logic [5:0]          sticky
);

   // R8: a trap only follows a sampled strobe
   p_pulse_needs_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      trap_pulse |-> $past(op_valid));

   // R7: outputs are quiet without a trap
   p_quiet_without_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_pulse |-> (trap_summary == '0 && trap_regmask == '0));

   // R7: at most one register bit
   p_regmask_onehot0_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(trap_regmask));

   // R7: flag traps name exactly one register, screening traps none
   p_flag_mask_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_pulse && $past(op_kind) == 2'd0) |-> $countones(trap_regmask) == 1);

   p_screen_mask_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_pulse && $past(op_kind) != 2'd0) |-> trap_regmask == '0);

   // R6: completion marker follows the qualifier
   p_swc_marker_r6: assert property (@(posedge clk) disable iff (!rst_n)
      trap_pulse |-> (trap_summary[6] == $past(swc)));

   // R2: without a write, sticky bits only accumulate
   p_sticky_accumulates_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sticky_wr) |-> ((sticky & $past(sticky)) == $past(sticky)));

   // R13: reserved kind is silent
   p_reserved_silent_r13: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_kind) == 2'd3 && !$past(sticky_wr)) |-> (!trap_pulse && $stable(sticky)));

endmodule

bind fpx_trap_ctrl fpx_trap_ctrl_chk #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .op_valid     (op_valid),
   .op_kind      (op_kind),
   .swc          (swc),
   .sticky_wr    (sticky_wr),
   .trap_pulse   (trap_pulse),
   .trap_summary (trap_summary),
   .trap_regmask (trap_regmask),
   .sticky       (sticky)
);

// File: tb/test_fpx_trap_ctrl.sv
`timescale 1ns/1ps
module test_fpx_trap_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [1:0]  op_kind = 2'd0;
   logic [5:0]  flags = '0, ignore_mask = '0, enable_mask = '0;
   logic [4:0]  dest_reg = '0;
   logic        swc = 1'b0, user_mode = 1'b0, flush_inputs = 1'b0;
   logic [63:0] operand = '0;
   logic        sticky_wr = 1'b0;
   logic [5:0]  sticky_wdata = '0;
   logic        trap_pulse;
   logic [6:0]  trap_summary;
   logic [31:0] trap_regmask;
   logic [5:0]  sticky;

   int checks = 0;
   int errors = 0;
   logic [5:0] exp_sticky = '0;

   always #2 clk = ~clk;

   fpx_trap_ctrl i_fpx_trap_ctrl (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
      .flags(flags), .ignore_mask(ignore_mask), .enable_mask(enable_mask),
      .dest_reg(dest_reg), .swc(swc), .user_mode(user_mode),
      .flush_inputs(flush_inputs), .operand(operand), .sticky_wr(sticky_wr),
      .sticky_wdata(sticky_wdata), .trap_pulse(trap_pulse),
      .trap_summary(trap_summary), .trap_regmask(trap_regmask), .sticky(sticky)
   );

   task automatic check(string tag, logic [45:0] act, logic [45:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: actual pulse/summary/mask/sticky=%h expected=%h", tag, act, expv);
      end
   endtask

   // one request: drive at a falling edge, compare at the next falling edge
   task automatic step(string tag, bit v, logic [1:0] k, logic [5:0] f, logic [5:0] ig,
                       logic [5:0] en, logic [4:0] rg, bit s, bit um, bit fz,
                       logic [63:0] opd, bit wr, logic [5:0] wd);
      logic        e_trap;
      logic [6:0]  e_sum;
      logic [31:0] e_mask;
      logic [5:0]  e_set;
      logic [5:0]  kept;
      logic [10:0] ex;
      logic [51:0] fr;
      op_valid = v; op_kind = k; flags = f; ignore_mask = ig; enable_mask = en;
      dest_reg = rg; swc = s; user_mode = um; flush_inputs = fz; operand = opd;
      sticky_wr = wr; sticky_wdata = wd;
      e_trap = 1'b0; e_sum = '0; e_mask = '0; e_set = '0;
      ex = opd[62:52]; fr = opd[51:0];
      if (v && k == 2'd0) begin
         e_set = f;
         kept  = f & ~ig;
         if (!s) begin
            e_trap = (kept != 0);
            e_sum  = {1'b0, kept};
         end else begin
            e_trap = um ? ((kept & en) != 0) : (kept != 0);
            e_sum  = {1'b1, kept & en};
         end
         if (e_trap) e_mask = 32'd1 << rg;
         else        e_sum  = '0;
      end else if (v && (k == 2'd1 || k == 2'd2)) begin
         if (s) begin
            if (ex == 0 && fr != 0 && !fz) begin e_trap = 1; e_sum = 7'h41; end
         end else if (ex == 0 && fr != 0) begin
            e_trap = 1; e_sum = 7'h01;
         end else if (ex == 11'h7ff && (k == 2'd1 || fr != 0)) begin
            e_trap = 1; e_sum = 7'h01; e_set = 6'h01;
         end
      end
      exp_sticky = (wr ? wd : exp_sticky) | e_set;
      @(negedge clk);
      check(tag, {trap_pulse, trap_summary, trap_regmask, sticky},
                 {e_trap, e_sum, e_mask, exp_sticky});
   endtask

   task automatic idle(string tag);
      step(tag, 0, 2'd0, 6'h3f, 0, 6'h3f, 0, 0, 0, 0, 64'd0, 0, 0);
   endtask

   function automatic logic [63:0] pick_operand(int cls);
      logic [51:0] fr;
      logic        sg;
      fr = {$urandom(), $urandom()} & 52'hf_ffff_ffff_ffff;
      if (fr == 0) fr = 52'd1;
      sg = $urandom() % 2;
      case (cls)
         0: return {sg, 63'd0};
         1: return {sg, 11'd0, fr};
         2: return {sg, 11'd1 + 11'($urandom() % 2046), fr};
         3: return {sg, 11'h7ff, 52'd0};
         4: return {sg, 11'h7ff, fr};
         default: return {$urandom(), $urandom()};
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1 reset", {trap_pulse, trap_summary, trap_regmask, sticky}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", {trap_pulse, trap_summary, trap_regmask, sticky}, '0);

      // directed corner cases
      step("R2 R3 all ignored still sticky", 1, 0, 6'h3f, 6'h3f, 0, 3, 0, 0, 0, 0, 0, 0);
      step("R2 write clears", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 6'h00);
      step("R3 R7 enable not used", 1, 0, 6'h14, 6'h10, 6'h00, 5, 0, 1, 0, 0, 0, 0);
      idle("R8 pulse one cycle");
      step("R4 user disabled no trap", 1, 0, 6'h08, 0, 6'h00, 7, 1, 1, 0, 0, 0, 0);
      step("R5 R6 system marker only", 1, 0, 6'h08, 0, 6'h00, 7, 1, 0, 0, 0, 0, 0);
      step("R4 R7 user enabled reg31", 1, 0, 6'h02, 6'h01, 6'h02, 31, 1, 1, 0, 0, 0, 0);
      step("R2 write with flags", 1, 0, 6'h20, 6'h20, 0, 1, 0, 0, 0, 0, 1, 6'h04);
      step("R2 write clear", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 6'h00);
      step("R10 arith infinity", 1, 1, 0, 0, 0, 9, 0, 0, 0, 64'hfff0_0000_0000_0000, 0, 0);
      step("R2 write clear", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 6'h00);
      step("R11 compare infinity passes", 1, 2, 0, 0, 0, 9, 0, 0, 0, 64'h7ff0_0000_0000_0000, 0, 0);
      step("R11 compare NaN traps", 1, 2, 0, 0, 0, 9, 0, 0, 0, 64'h7ff8_0000_0000_0000, 0, 0);
      step("R2 write clear", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 6'h00);
      step("R9 denormal no sticky", 1, 1, 0, 0, 0, 2, 0, 0, 0, 64'h0000_0000_0000_0001, 0, 0);
      step("R12 negative denormal", 1, 2, 0, 0, 0, 2, 1, 0, 0, 64'h800f_ffff_ffff_ffff, 0, 0);
      step("R12 flush suppresses", 1, 1, 0, 0, 0, 2, 1, 0, 1, 64'h800f_ffff_ffff_ffff, 0, 0);
      step("R12 negative zero passes", 1, 1, 0, 0, 0, 2, 1, 0, 0, 64'h8000_0000_0000_0000, 0, 0);
      step("R12 NaN passes", 1, 1, 0, 0, 0, 2, 1, 0, 0, 64'h7ff0_0000_0000_0001, 0, 0);
      step("R13 reserved kind", 1, 3, 6'h3f, 0, 6'h3f, 4, 0, 0, 0, 64'h7ff0_0000_0000_0000, 0, 0);

      // constrained random
      for (int n = 0; n < 3000; n++) begin
         logic [1:0] k;
         bit         s;
         string      tg;
         k = 2'($urandom() % 4);
         s = ($urandom() % 2) == 1;
         if (k == 0)       tg = s ? "R4 R5 random swc flags" : "R3 random flags";
         else if (k == 3)  tg = "R13 random reserved";
         else if (s)       tg = "R12 random swc screen";
         else              tg = (k == 2) ? "R11 random compare screen" : "R9 R10 random screen";
         step(tg, ($urandom() % 5) != 0, k, 6'($urandom()), 6'($urandom()), 6'($urandom()),
              5'($urandom()), s, ($urandom() % 2) == 1, ($urandom() % 4) == 0,
              pick_operand(int'($urandom() % 6)), ($urandom() % 10) == 0, 6'($urandom()));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule